// File: doc/BRIEF.md
# Averaging Measurement Sequencer with Limit Checking

This block schedules conversions on a 10-bit converter shared by three measurement channels: two external inputs and the supply rail. A periodic conversion tick starts one conversion at a time over a request/done handshake. Each result is either added into a 16-sample running sum or, when averaging is bypassed, used on its own. The block then writes an 8-bit reading for the channel and compares that reading against the channel's low and high limits.

A limit violation sets a sticky status bit and drives the alert output. The status read logic clears each bit by pulsing its clear line. In round-robin mode the channels take turns. In single-channel mode one selected channel is converted again and again. The limits arrive from the surrounding register file as plain inputs, and the readings and status leave the same way.

Top module: `avg_limit_seq`

## Requirements
- R1: After reset, `readings`, `status`, `alert` and `adcReq` are all zero.
- R2: A `tick` while no conversion is outstanding raises `adcReq` on the next cycle. `adcReq` stays high until a cycle with `adcDone` high, and `adcChan` shows the channel being converted. A `tick` seen while a request is outstanding has no effect.
- R3: In round-robin mode (`cfgSingle`=0), the channels are converted in the order 0, 1, 2 and then back to 0. A channel keeps its turn until its group of samples is complete.
- R4: With averaging on (`cfgAvgOff`=0), a channel's reading changes only on its 16th accepted sample. The new reading is bits [9:2] of the 14-bit sum of the 16 samples shifted right by 4. The sum starts from zero with the first sample of the group.
- R5: With averaging off (`cfgAvgOff`=1), every accepted sample writes `adcData[9:2]` to the channel's reading.
- R6: In single-channel mode (`cfgSingle`=1), only the channel given by `cfgChanSel` is converted. A select value of 3 to 7 converts channel 0.
- R7: The reading of channel c sits in `readings[8c+7:8c]`. A new reading that is below the low limit (`lowLimits[8c+7:8c]`) sets `status[2c]`. A new reading that is above the high limit (`highLimits[8c+7:8c]`) sets `status[2c+1]`. Both comparisons are unsigned, and a reading equal to a limit sets neither bit.
- R8: A status bit stays set until its `stsClr` bit is high. If a set and a clear of the same bit fall in the same cycle, the set wins.
- R9: `alert` is high exactly when at least one status bit is set.
- R10: Any change to `cfgAvgOff`, `cfgSingle` or `cfgChanSel` aborts the current group. The samples gathered so far are discarded and any outstanding request drops on the next cycle. The next tick starts at channel 0 in round-robin mode, or at the selected channel in single-channel mode.
- R11: An `adcDone` pulse that arrives while no request is outstanding changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Conversion tick, one pulse per conversion slot |
| cfgAvgOff | input | 1 | 1 = bypass 16-sample averaging |
| cfgSingle | input | 1 | 1 = single-channel mode |
| cfgChanSel | input | 3 | Channel selected in single-channel mode |
| adcReq | output | 1 | Conversion request to the converter |
| adcChan | output | 2 | Channel to convert |
| adcDone | input | 1 | Converter result valid, one-cycle pulse |
| adcData | input | 10 | Converter result |
| lowLimits | input | 24 | Low limit per channel, 8 bits each |
| highLimits | input | 24 | High limit per channel, 8 bits each |
| stsClr | input | 6 | Per-bit status clear from the status read logic |
| readings | output | 24 | Reading per channel, 8 bits each |
| status | output | 6 | Sticky violation bits, low then high per channel |
| alert | output | 1 | Any status bit set |

## Verification
Averaging is driven with random 10-bit samples in round-robin mode. This separates a correct 16-sample group from wrong sample counts, a missing sum restart and a wrong shift, because every intermediate conversion must leave the readings untouched. Bypass mode is first tried with directed samples whose readings land exactly on, one below and one above each limit, which tells strict comparisons from inclusive ones, and then with random data. Single-channel runs use an in-range select and an out-of-range select, and configuration changes are made both in the middle of a group and while a request is outstanding. Together these show whether stale sums survive an abort and whether a stray done pulse is ignored.

// File: rtl/avg_seq_pkg.sv
package avg_seq_pkg;
  typedef enum logic {ST_IDLE, ST_WAIT} seqState_t;

  typedef struct packed {
    logic take;    // a sample is accepted this cycle
    logic first;   // accepted sample opens a new group
    logic commit;  // accepted sample closes the group
  } dpStrobe_t;
endpackage

// File: rtl/avg_seq_ctrl.sv
module avg_seq_ctrl
  import avg_seq_pkg::*;
#(
  parameter int NCH  = 3,
  parameter int NAVG = 16,
  parameter int SELW = 3,
  localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int SHW = $clog2(NAVG)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            tick,
  input  logic            cfgAvgOff,
  input  logic            cfgSingle,
  input  logic [SELW-1:0] cfgChanSel,
  input  logic            adcDone,
  output logic            adcReq,
  output logic [CW-1:0]   adcChan,
  output dpStrobe_t       strobe
);
  localparam int CFGW = SELW + 2;

  seqState_t       state;
  logic [CFGW-1:0] cfgQ;
  logic [CW-1:0]   chanQ;
  logic [SHW-1:0]  cntQ;

  logic [CFGW-1:0] cfgNow;
  logic            cfgChg;
  logic [CW-1:0]   selChan;
  logic            lastSample;
  logic            accept;

  assign cfgNow     = {cfgAvgOff, cfgSingle, cfgChanSel};
  assign cfgChg     = cfgNow != cfgQ;
  assign selChan    = (int'(cfgChanSel) < NCH) ? CW'(cfgChanSel) : '0;
  assign lastSample = cfgAvgOff || (cntQ == SHW'(NAVG - 1));
  assign accept     = (state == ST_WAIT) && adcDone && !cfgChg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cfgQ  <= '0;
      chanQ <= '0;
      cntQ  <= '0;
    end else begin
      cfgQ <= cfgNow;
      if (cfgChg) begin
        state <= ST_IDLE;
        cntQ  <= '0;
        chanQ <= cfgSingle ? selChan : '0;
      end else begin
        unique case (state)
          ST_IDLE: if (tick) state <= ST_WAIT;
          ST_WAIT: if (adcDone) begin
            state <= ST_IDLE;
            if (lastSample) begin
              cntQ <= '0;
              if (cfgSingle)                  chanQ <= selChan;
              else if (chanQ == CW'(NCH - 1)) chanQ <= '0;
              else                            chanQ <= chanQ + 1'b1;
            end else begin
              cntQ <= cntQ + 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign adcReq        = state == ST_WAIT;
  assign adcChan       = chanQ;
  assign strobe.take   = accept;
  assign strobe.first  = cntQ == '0;
  assign strobe.commit = accept && lastSample;
endmodule

// File: rtl/avg_seq_dpath.sv
module avg_seq_dpath
  import avg_seq_pkg::*;
#(
  parameter int NCH  = 3,
  parameter int DW   = 10,
  parameter int RW   = 8,
  parameter int NAVG = 16,
  localparam int CW   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int SHW  = $clog2(NAVG),
  localparam int ACCW = DW + SHW
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [CW-1:0]     chan,
  input  logic              avgOff,
  input  logic [DW-1:0]     adcData,
  input  logic [NCH*RW-1:0] lowLimits,
  input  logic [NCH*RW-1:0] highLimits,
  input  logic [2*NCH-1:0]  stsClr,
  output logic [NCH*RW-1:0] readings,
  output logic [2*NCH-1:0]  status
);
  logic [ACCW-1:0] accQ;
  logic [ACCW-1:0] sumNext;
  logic [DW-1:0]   avgVal;
  logic [RW-1:0]   newRd;

  assign sumNext = (strobe.first ? '0 : accQ) + ACCW'(adcData);
  assign avgVal  = avgOff ? adcData : sumNext[ACCW-1:SHW];
  assign newRd   = avgVal[DW-1:DW-RW];

  always_ff @(posedge clk) begin
    if (!rstN)            accQ <= '0;
    else if (strobe.take) accQ <= sumNext;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    logic hit, setLo, setHi;
    assign hit   = strobe.commit && (chan == CW'(i));
    assign setLo = hit && (newRd < lowLimits[i*RW +: RW]);
    assign setHi = hit && (newRd > highLimits[i*RW +: RW]);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        readings[i*RW +: RW] <= '0;
        status[2*i]          <= 1'b0;
        status[2*i+1]        <= 1'b0;
      end else begin
        if (hit) readings[i*RW +: RW] <= newRd;
        status[2*i]   <= setLo | (status[2*i]   & ~stsClr[2*i]);
        status[2*i+1] <= setHi | (status[2*i+1] & ~stsClr[2*i+1]);
      end
    end
  end
endmodule

// File: rtl/avg_limit_seq.sv
module avg_limit_seq
  import avg_seq_pkg::*;
#(
  parameter int NCH  = 3,
  parameter int DW   = 10,
  parameter int RW   = 8,
  parameter int NAVG = 16,
  parameter int SELW = 3,
  localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              cfgAvgOff,
  input  logic              cfgSingle,
  input  logic [SELW-1:0]   cfgChanSel,
  output logic              adcReq,
  output logic [CW-1:0]     adcChan,
  input  logic              adcDone,
  input  logic [DW-1:0]     adcData,
  input  logic [NCH*RW-1:0] lowLimits,
  input  logic [NCH*RW-1:0] highLimits,
  input  logic [2*NCH-1:0]  stsClr,
  output logic [NCH*RW-1:0] readings,
  output logic [2*NCH-1:0]  status,
  output logic              alert
);
  dpStrobe_t strobe;

  avg_seq_ctrl #(.NCH(NCH), .NAVG(NAVG), .SELW(SELW)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick),
    .cfgAvgOff(cfgAvgOff), .cfgSingle(cfgSingle), .cfgChanSel(cfgChanSel),
    .adcDone(adcDone), .adcReq(adcReq), .adcChan(adcChan), .strobe(strobe)
  );

  avg_seq_dpath #(.NCH(NCH), .DW(DW), .RW(RW), .NAVG(NAVG)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .chan(adcChan),
    .avgOff(cfgAvgOff), .adcData(adcData),
    .lowLimits(lowLimits), .highLimits(highLimits), .stsClr(stsClr),
    .readings(readings), .status(status)
  );

  assign alert = |status;
endmodule

// File: rtl/avg_limit_seq_chk.sv
module avg_limit_seq_chk #(
  parameter int NCH  = 3,
  parameter int RW   = 8,
  parameter int SELW = 3,
  localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgAvgOff,
  input logic              cfgSingle,
  input logic [SELW-1:0]   cfgChanSel,
  input logic              adcReq,
  input logic [CW-1:0]     adcChan,
  input logic              adcDone,
  input logic [2*NCH-1:0]  stsClr,
  input logic [NCH*RW-1:0] readings,
  input logic [2*NCH-1:0]  status
);
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    adcReq && !adcDone &&
    ({cfgAvgOff, cfgSingle, cfgChanSel} == $past({cfgAvgOff, cfgSingle, cfgChanSel}))
    |=> adcReq);

  assert_chan_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    adcReq |-> (int'(adcChan) < NCH));

  assert_reading_after_done_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(readings) |-> $past(adcDone));

  assert_status_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (($past(status) & ~$past(stsClr) & ~status) == '0));

  assert_stray_done_R11: assert property (@(posedge clk) disable iff (!rstN)
    !adcReq && adcDone |=> $stable(readings));
endmodule

bind avg_limit_seq avg_limit_seq_chk #(.NCH(NCH), .RW(RW), .SELW(SELW)) u_chk (.*);

// File: tb/avg_limit_seq_bench.sv
module avg_limit_seq_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        cfgAvgOff = 1'b0;
  logic        cfgSingle = 1'b0;
  logic [2:0]  cfgChanSel = 3'd0;
  logic        adcReq;
  logic [1:0]  adcChan;
  logic        adcDone = 1'b0;
  logic [9:0]  adcData = '0;
  logic [23:0] lowLimits = '0;
  logic [23:0] highLimits = {3{8'hFF}};
  logic [5:0]  stsClr = '0;
  logic [23:0] readings;
  logic [5:0]  status;
  logic        alert;

  int checks = 0;
  int fails = 0;

  // bench model
  int          mChan = 0;
  int          mCnt = 0;
  int          mAcc = 0;
  logic [23:0] mRd = '0;
  logic [5:0]  mSts = '0;

  always #5 clk = ~clk;

  avg_limit_seq u_avg_limit_seq (
    .clk(clk), .rstN(rstN), .tick(tick),
    .cfgAvgOff(cfgAvgOff), .cfgSingle(cfgSingle), .cfgChanSel(cfgChanSel),
    .adcReq(adcReq), .adcChan(adcChan), .adcDone(adcDone), .adcData(adcData),
    .lowLimits(lowLimits), .highLimits(highLimits), .stsClr(stsClr),
    .readings(readings), .status(status), .alert(alert)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int selOf(input logic [2:0] s);
    return (s < 3) ? int'(s) : 0;
  endfunction

  function automatic logic [7:0] toReading(input int avg);
    return 8'((avg >> 2) & 8'hFF);
  endfunction

  function automatic logic [5:0] violations(input int ch, input logic [7:0] rd);
    logic [5:0] v = '0;
    if (rd < lowLimits[ch*8 +: 8])  v[2*ch]   = 1'b1;
    if (rd > highLimits[ch*8 +: 8]) v[2*ch+1] = 1'b1;
    return v;
  endfunction

  task automatic checkOutputs(input string req);
    chk(req, readings, mRd);
    chk(req, status, mSts);
    chk("R9", alert, |mSts);
  endtask

  task automatic convert(input logic [9:0] d, input string req);
    logic [7:0] rd;
    bit commit = 0;
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    chk("R2 req", adcReq, 1'b1);
    chk(cfgSingle ? "R6 chan" : "R3 chan", adcChan, mChan);
    @(negedge clk) tick = 1'b1;           // ignored tick while waiting
    @(negedge clk) tick = 1'b0;
    chk("R2 hold", adcReq, 1'b1);
    adcDone = 1'b1; adcData = d;
    @(negedge clk) adcDone = 1'b0;
    chk("R2 drop", adcReq, 1'b0);
    if (cfgAvgOff) begin
      rd = toReading(int'(d)); commit = 1;
    end else begin
      mAcc = (mCnt == 0 ? 0 : mAcc) + int'(d);
      if (mCnt == 15) begin rd = toReading(mAcc >> 4); commit = 1; mCnt = 0; end
      else mCnt++;
    end
    if (commit) begin
      mRd[mChan*8 +: 8] = rd;
      mSts = mSts | violations(mChan, rd);
      mChan = cfgSingle ? selOf(cfgChanSel) : (mChan + 1) % 3;
    end
    checkOutputs(req);
  endtask

  task automatic setCfg(input logic off, input logic sgl, input logic [2:0] sel);
    @(negedge clk);
    if ({off, sgl, sel} != {cfgAvgOff, cfgSingle, cfgChanSel}) begin
      cfgAvgOff = off; cfgSingle = sgl; cfgChanSel = sel;
      mCnt = 0;
      mChan = sgl ? selOf(sel) : 0;
    end
    @(negedge clk);
  endtask

  task automatic clearSts(input logic [5:0] mask);
    @(negedge clk) stsClr = mask;
    @(negedge clk) stsClr = '0;
    mSts = mSts & ~mask;
    checkOutputs("R8");
  endtask

  initial begin
    #(2_000_000ns);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 readings", readings, 24'h0);
    chk("R1 status", status, 6'h0);
    chk("R1 alert", alert, 1'b0);
    chk("R1 req", adcReq, 1'b0);
    rstN = 1'b1;
    @(negedge clk);

    lowLimits  = {8'h10, 8'h20, 8'h30};
    highLimits = {8'hE0, 8'hD0, 8'hC0};

    // R3 / R4: round-robin averaging with random samples
    for (int i = 0; i < 96; i++) convert(10'($urandom), "R4");

    clearSts(6'h3F);

    // R5 / R7: bypass with boundary readings
    setCfg(1'b1, 1'b0, 3'd0);
    convert(10'h0C0, "R7 equal low");      // ch0 rd 0x30
    convert(10'h343, "R7 equal high");     // ch1 rd 0xD0
    convert(10'h03C, "R7 below low");      // ch2 rd 0x0F
    convert(10'h304, "R7 above high");     // ch0 rd 0xC1
    chk("R7 bits", status, 6'b01_00_10);
    clearSts(6'b00_00_10);                 // partial clear
    for (int i = 0; i < 30; i++) convert(10'($urandom), "R5");

    // R6: single-channel, averaging on, valid select
    setCfg(1'b0, 1'b1, 3'd2);
    for (int i = 0; i < 20; i++) convert(10'($urandom), "R6");
    // R6: out-of-range select maps to channel 0
    setCfg(1'b1, 1'b1, 3'd5);
    for (int i = 0; i < 4; i++) convert(10'($urandom), "R6 sel5");

    // R10: abort in the middle of an averaging group
    setCfg(1'b0, 1'b0, 3'd0);
    for (int i = 0; i < 5; i++) convert(10'h3FF, "R10 partial");
    setCfg(1'b0, 1'b1, 3'd1);
    checkOutputs("R10 abort");
    for (int i = 0; i < 16; i++) convert(10'($urandom), "R10 restart");

    // R10: abort with a request outstanding, then R11 stray done
    @(negedge clk) tick = 1'b1;
    @(negedge clk) begin tick = 1'b0; cfgSingle = 1'b0; end
    chk("R10 req pending", adcReq, 1'b1);
    @(negedge clk);
    chk("R10 req dropped", adcReq, 1'b0);
    mCnt = 0; mChan = 0;
    adcDone = 1'b1; adcData = 10'h2AA;
    @(negedge clk) adcDone = 1'b0;
    @(negedge clk);
    checkOutputs("R11");
    chk("R11 req", adcReq, 1'b0);
    for (int i = 0; i < 16; i++) convert(10'($urandom), "R10 rr restart");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule